// File: doc/BRIEF.md
# AHB-to-APB Protocol Bridge

This block sits between a high-performance system bus of the AHB-Lite kind and a low-power peripheral bus of the APB kind. On the system side it behaves as a slave; on the peripheral side it is the only master. Every selected, valid system-bus transfer becomes exactly one two-phase peripheral transfer (a setup cycle followed by one or more enable cycles). The system bus is held off with HREADY low until the peripheral reports completion.

Address, direction and write data are captured when the request is accepted. They are then presented unchanged on the peripheral bus for the whole transfer, so the system side is free to change its bus lines. Read data is captured in the cycle the peripheral signals ready. A peripheral error becomes the usual two-cycle ERROR response on the system bus. A five-state controller (idle, setup, access, wait, complete) drives a fixed PSEL/PENABLE/HREADY pattern in each state. Only one transfer is in flight at a time. New requests are accepted only in the idle state.

Top module: `ahb2apb_bridge`

## Requirements
- R1: After the active-low synchronous reset `rstN` is released, pSel=0, pEnable=0, hReady=1 and hResp=0 (OKAY).
- R2: A request is accepted in the idle state only when hSel=1 and hTrans is 2'b10 (NONSEQ) or 2'b11 (SEQ). hTrans 2'b00 (IDLE), hTrans 2'b01 (BUSY), or hSel=0 leaves pSel at 0 in the following cycle.
- R3: In the cycle after acceptance (setup), pSel=1, pEnable=0 and hReady=0. pAddr, pWrite and pWdata equal the hAddr, hWrite and hWdata sampled at acceptance (hWdata only for writes).
- R4: The setup cycle is always followed by an enable cycle with pSel=1, pEnable=1 and hReady=0. pEnable is never 1 while pSel is 0.
- R5: While pReady=0 during an enable cycle, the next cycle again has pSel=1, pEnable=1 and hReady=0.
- R6: pAddr, pWrite and pWdata do not change from the setup cycle until the enable cycle in which pReady=1, whatever the system bus does meanwhile.
- R7: In the cycle after an enable cycle with pReady=1 and pSlvErr=0, pSel=0, pEnable=0, hReady=1 and hResp=0. The following cycle is idle.
- R8: For a read, hRdata equals the pRdata presented in the enable cycle with pReady=1, from the next cycle onward, and keeps that value until the next read completes.
- R9: If pSlvErr=1 with pReady=1 in an enable cycle, the next two cycles have hResp=1 (ERROR) with hReady=0, and then hResp=1 with hReady=1, and pSel=0 in both. hResp is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hSel | input | 1 | Slave select from the system bus decoder |
| hTrans | input | 2 | Transfer type (00 idle, 01 busy, 10 nonseq, 11 seq) |
| hAddr | input | ADDR_W | System bus address |
| hWrite | input | 1 | 1 = write, 0 = read |
| hWdata | input | DATA_W | System bus write data |
| hRdata | output | DATA_W | Read data returned to the system bus |
| hReady | output | 1 | 1 = transfer done / bridge ready |
| hResp | output | 1 | 0 = OKAY, 1 = ERROR |
| pSel | output | 1 | Peripheral select |
| pEnable | output | 1 | Peripheral enable phase |
| pAddr | output | ADDR_W | Peripheral address |
| pWrite | output | 1 | Peripheral direction |
| pWdata | output | DATA_W | Peripheral write data |
| pRdata | input | DATA_W | Peripheral read data |
| pReady | input | 1 | Peripheral ready (ends the enable phase) |
| pSlvErr | input | 1 | Peripheral error, valid with pReady |

## Verification
The assertions check the peripheral-side handshake shape on every cycle: setup is always followed by enable, waits hold select and enable, the transfer drops both after ready, and address, direction and data stay stable while a transfer is open. They also check that hReady stays low while the peripheral is selected, and that the first ERROR cycle is always followed by the second. Only the bench scenarios show the values themselves. These are that the captured address and data match what the system bus offered at acceptance, that read data equals what the peripheral returned, that idle and busy transfer types are ignored, and that an error appears on the right transfer. A behavioural reference model covers these for transfers with zero to several wait states.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACCESS = 3'd2,
    ST_WAIT   = 3'd3,
    ST_DONE   = 3'd4
  } brgState_t;

  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;   // capture system-bus address phase
    logic takeResp;  // capture peripheral response
    logic clrErr;    // forget a reported error
  } brgStrobe_t;

  function automatic logic isActiveTrans(input logic [1:0] t);
    return (t == TR_NONSEQ) || (t == TR_SEQ);
  endfunction

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hSel,
  input  logic [1:0] hTrans,
  input  logic       pReady,
  input  logic       errLatched,
  output brgStrobe_t strb,
  output logic       pSel,
  output logic       pEnable,
  output logic       hReady,
  output logic       hResp
);

  brgState_t state, stateNxt;
  logic      errShown, errShownNxt;
  logic      errFirst;

  // first error cycle: completion with an unreported error
  assign errFirst = (state == ST_DONE) && errLatched && !errShown;

  always_comb begin
    stateNxt    = state;
    errShownNxt = errShown;
    strb        = '0;
    unique case (state)
      ST_IDLE: begin
        if (hSel && isActiveTrans(hTrans)) begin
          strb.takeReq = 1'b1;
          stateNxt     = ST_SETUP;
        end
      end
      ST_SETUP: stateNxt = ST_ACCESS;
      ST_ACCESS, ST_WAIT: begin
        if (pReady) begin
          strb.takeResp = 1'b1;
          stateNxt      = ST_DONE;
        end else begin
          stateNxt = ST_WAIT;
        end
      end
      ST_DONE: begin
        if (errFirst) begin
          errShownNxt = 1'b1;
        end else begin
          errShownNxt = 1'b0;
          strb.clrErr = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errShown <= 1'b0;
    end else begin
      state    <= stateNxt;
      errShown <= errShownNxt;
    end
  end

  // fixed output pattern per state
  always_comb begin
    pSel    = (state == ST_SETUP) || (state == ST_ACCESS) || (state == ST_WAIT);
    pEnable = (state == ST_ACCESS) || (state == ST_WAIT);
    hReady  = (state == ST_IDLE) || ((state == ST_DONE) && !errFirst);
    hResp   = (state == ST_DONE) && errLatched;
  end

endmodule

// File: rtl/bridge_dpath.sv
module bridge_dpath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  brgStrobe_t        strb,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic              hWrite,
  input  logic [DATA_W-1:0] hWdata,
  input  logic [DATA_W-1:0] pRdata,
  input  logic              pSlvErr,
  output logic [ADDR_W-1:0] pAddr,
  output logic              pWrite,
  output logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] hRdata,
  output logic              errLatched
);

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strb.takeReq) begin
      addrQ  <= hAddr;
      writeQ <= hWrite;
      if (hWrite) wdataQ <= hWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else if (strb.takeResp) begin
      if (!writeQ) rdataQ <= pRdata;
      errQ <= pSlvErr;
    end else if (strb.clrErr) begin
      errQ <= 1'b0;
    end
  end

  assign pAddr      = addrQ;
  assign pWrite     = writeQ;
  assign pWdata     = wdataQ;
  assign hRdata     = rdataQ;
  assign errLatched = errQ;

endmodule

// File: rtl/ahb2apb_bridge.sv
module ahb2apb_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hSel,
  input  logic [1:0]        hTrans,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic              hWrite,
  input  logic [DATA_W-1:0] hWdata,
  output logic [DATA_W-1:0] hRdata,
  output logic              hReady,
  output logic              hResp,
  output logic              pSel,
  output logic              pEnable,
  output logic [ADDR_W-1:0] pAddr,
  output logic              pWrite,
  output logic [DATA_W-1:0] pWdata,
  input  logic [DATA_W-1:0] pRdata,
  input  logic              pReady,
  input  logic              pSlvErr
);

  brgStrobe_t strb;
  logic       errLatched;

  bridge_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hSel       (hSel),
    .hTrans     (hTrans),
    .pReady     (pReady),
    .errLatched (errLatched),
    .strb       (strb),
    .pSel       (pSel),
    .pEnable    (pEnable),
    .hReady     (hReady),
    .hResp      (hResp)
  );

  bridge_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hAddr      (hAddr),
    .hWrite     (hWrite),
    .hWdata     (hWdata),
    .pRdata     (pRdata),
    .pSlvErr    (pSlvErr),
    .pAddr      (pAddr),
    .pWrite     (pWrite),
    .pWdata     (pWdata),
    .hRdata     (hRdata),
    .errLatched (errLatched)
  );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hSel,
  input logic [1:0]        hTrans,
  input logic              hReady,
  input logic              hResp,
  input logic              pSel,
  input logic              pEnable,
  input logic [ADDR_W-1:0] pAddr,
  input logic              pWrite,
  input logic [DATA_W-1:0] pWdata,
  input logic              pReady
);

  // R2: peripheral select rises only after an accepted valid request
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pSel) |-> $past(hSel && hTrans[1] && hReady));

  // R3: system side stalled while peripheral selected
  p_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    pSel |-> !hReady);

  // R4: enable implies select
  p_en_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    pEnable |-> pSel);

  // R4: setup is followed by enable
  p_setup_access_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !pEnable) |=> (pSel && pEnable));

  // R5: wait holds the enable phase
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pReady) |=> (pSel && pEnable));

  // R6: transfer attributes stable while open
  p_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && !(pEnable && pReady)) |=> ($stable(pAddr) && $stable(pWrite) && $stable(pWdata)));

  // R7: ready ends the transfer
  p_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && pReady) |=> (!pSel && !pEnable));

  // R9: first ERROR cycle is followed by the second
  p_err_seq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hResp && !hReady) |=> (hResp && hReady));

  // R9: ERROR never while the peripheral is selected
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    hResp |-> !pSel);

endmodule

bind ahb2apb_bridge bridge_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .hSel    (hSel),
  .hTrans  (hTrans),
  .hReady  (hReady),
  .hResp   (hResp),
  .pSel    (pSel),
  .pEnable (pEnable),
  .pAddr   (pAddr),
  .pWrite  (pWrite),
  .pWdata  (pWdata),
  .pReady  (pReady)
);

// File: tb/sim_ahb2apb_bridge.sv
`timescale 1ns/1ps
module sim_ahb2apb_bridge;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hSel = 1'b0;
  logic [1:0]    hTrans = 2'b00;
  logic [AW-1:0] hAddr = '0;
  logic          hWrite = 1'b0;
  logic [DW-1:0] hWdata = '0;
  logic [DW-1:0] hRdata;
  logic          hReady, hResp, pSel, pEnable, pWrite;
  logic [AW-1:0] pAddr;
  logic [DW-1:0] pWdata;
  logic [DW-1:0] pRdata = '0;
  logic          pReady = 1'b0;
  logic          pSlvErr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ahb2apb_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hTrans(hTrans), .hAddr(hAddr),
    .hWrite(hWrite), .hWdata(hWdata), .hRdata(hRdata), .hReady(hReady),
    .hResp(hResp), .pSel(pSel), .pEnable(pEnable), .pAddr(pAddr),
    .pWrite(pWrite), .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .pSlvErr(pSlvErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 setup, 2 enable, 3 complete, 4 first error cycle
  int            mPhase = 0;
  logic [AW-1:0] mAddr = '0;
  logic          mWrite = 1'b0;
  logic [DW-1:0] mWdata = '0;
  logic [DW-1:0] mRdata = '0;
  bit            mErr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mAddr = '0; mWrite = 0; mWdata = '0; mRdata = '0; mErr = 0;
    end else begin
      case (mPhase)
        0: if (hSel && (hTrans == 2'b10 || hTrans == 2'b11)) begin
             mAddr = hAddr; mWrite = hWrite;
             if (hWrite) mWdata = hWdata;
             mPhase = 1;
           end
        1: mPhase = 2;
        2: if (pReady) begin
             if (!mWrite) mRdata = pRdata;
             mErr = pSlvErr;
             mPhase = pSlvErr ? 4 : 3;
           end
        4: mPhase = 3;
        default: begin mPhase = 0; mErr = 0; end
      endcase
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3 R4 pSel", pSel, (mPhase == 1 || mPhase == 2));
      chk("R4 R5 pEnable", pEnable, (mPhase == 2));
      chk("R7 hReady", hReady, (mPhase == 0 || mPhase == 3));
      chk("R9 hResp", hResp, (mPhase == 4 || (mPhase == 3 && mErr)));
      chk("R8 hRdata", hRdata, mRdata);
      if (mPhase == 1 || mPhase == 2) begin
        chk("R6 pAddr", pAddr, mAddr);
        chk("R6 pWrite", pWrite, mWrite);
        if (mWrite) chk("R6 pWdata", pWdata, mWdata);
      end
    end
  end

  task automatic xfer(input bit wr, input logic [1:0] tr, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input int waits, input bit err,
                      input logic [DW-1:0] rd);
    @(negedge clk);
    hSel = 1; hTrans = tr; hAddr = a; hWrite = wr; hWdata = wd; pReady = 0;
    @(negedge clk);  // setup cycle
    chk("R3 setup pSel", pSel, 1);
    chk("R3 setup pEnable", pEnable, 0);
    chk("R3 pAddr", pAddr, a);
    if (wr) chk("R3 pWdata", pWdata, wd);
    hSel = 0; hTrans = 2'b00; hAddr = ~a; hWrite = ~wr; hWdata = ~wd;
    @(negedge clk);  // first enable cycle
    chk("R4 access pEnable", pEnable, 1);
    pReady = (waits == 0); pSlvErr = err; pRdata = rd;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R5 wait pEnable", pEnable, 1);
      chk("R6 wait pAddr", pAddr, a);
      pReady = (i == waits - 1);
    end
    @(negedge clk);
    pReady = 0; pSlvErr = 0; pRdata = 32'hDEAD_0000;
    if (err) begin
      chk("R9 first err hResp", hResp, 1);
      chk("R9 first err hReady", hReady, 0);
      @(negedge clk);
      chk("R9 second err hResp", hResp, 1);
      chk("R9 second err hReady", hReady, 1);
    end else begin
      chk("R7 complete hReady", hReady, 1);
      chk("R7 complete pSel", pSel, 0);
      chk("R7 complete hResp", hResp, 0);
    end
    if (!wr) chk("R8 read data", hRdata, rd);
    while (mPhase != 0) @(negedge clk);
  endtask

  task automatic ignored(input bit sel, input logic [1:0] tr);
    @(negedge clk);
    hSel = sel; hTrans = tr; hAddr = 32'h5555_AAAA; hWrite = 1;
    @(negedge clk);
    chk("R2 ignored pSel", pSel, 0);
    hSel = 0; hTrans = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 pSel", pSel, 0);
    chk("R1 pEnable", pEnable, 0);
    chk("R1 hReady", hReady, 1);
    chk("R1 hResp", hResp, 0);

    ignored(1'b0, 2'b10);
    ignored(1'b1, 2'b00);
    ignored(1'b1, 2'b01);

    xfer(1, 2'b10, 32'h0000_1000, 32'hCAFE_0001, 0, 0, '0);
    xfer(0, 2'b10, 32'h0000_2004, '0, 0, 0, 32'h1234_5678);
    xfer(1, 2'b11, 32'h0000_3008, 32'hA5A5_5A5A, 3, 0, '0);
    xfer(0, 2'b11, 32'h0000_400C, '0, 2, 0, 32'h8765_4321);
    xfer(1, 2'b10, 32'h0000_5010, 32'h0BAD_F00D, 0, 1, '0);
    xfer(0, 2'b10, 32'h0000_6014, '0, 1, 1, 32'h0F0F_F0F0);
    xfer(0, 2'b10, 32'h0000_7018, '0, 4, 0, 32'hFFFF_0001);
    xfer(1, 2'b10, 32'h0000_801C, 32'h1111_2222, 1, 0, '0);
    @(negedge clk);
    chk("R8 hRdata held after write", hRdata, 32'hFFFF_0001);
    ignored(1'b1, 2'b01);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule